// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache placed between a processor request port and a slower main-memory port. An incoming byte address is divided into three fields: a tag, a set index and a byte select. The block reads both lines of the indexed set and compares their stored tags with the address tag. When one of them matches, the addressed word is returned or updated in place. When neither matches, the block chooses a line to give up. If that line holds modified data, the block first copies it out to memory. It then reads the new block in.

A line is one 32-bit word. Each line keeps a valid flag, a modified flag and one recency bit. Writes change only the cache. Main memory learns about a modified line only when that line is evicted. The processor may have one request outstanding at a time, and it receives its result through a ready/valid response. Memory traffic uses a request that is held until a one-cycle acknowledge arrives.

Top module: `sa2_wb_cache`

## Requirements
- R1: After a synchronous active-low reset, every line is invalid, `cpu_req_ready` is 1, and both `cpu_rsp_valid` and `mem_req_valid` are 0.
- R2: A read miss issues one memory read at the word-aligned address {tag, set, 2'b00}. With the default parameters the tag is bits 23:10, the set is bits 9:2 and the byte select is bits 1:0. The memory request and its address stay stable until `mem_ack`, and the response carries the word read from memory.
- R3: A hit causes no memory request. Its response becomes valid at the second rising edge after the request is accepted.
- R4: A write hit updates only the cached word and issues no memory request. A later read of the same address returns the new word.
- R5: Bit i of `cpu_req_be` selects byte i (bits 8i+7:8i) of `cpu_req_wdata`. Bytes whose enable is clear keep their previous value.
- R6: On a miss, an invalid way is filled before any valid way is replaced. Two blocks with the same set index and different tags can therefore be resident together.
- R7: A miss in a set whose two ways are both valid replaces the way that was not accessed most recently.
- R8: A modified victim is written to memory at {stored tag, set, 2'b00}, with its cached word as data. This write happens before the read that fills the line.
- R9: A victim that is not modified is overwritten without any memory write.
- R10: A write miss first reads the block from memory, then merges the write data under the byte enables, marks the line modified and responds with the merged word.
- R11: `cpu_rsp_valid` stays high, with `cpu_rsp_rdata` unchanged, until `cpu_rsp_ready` is seen high.
- R12: `cpu_req_ready` is low from the acceptance of a request until its response has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W (24) | Byte address |
| cpu_req_wdata | input | DATA_W (32) | Write data |
| cpu_req_be | input | DATA_W/8 (4) | Byte enables for writes |
| cpu_rsp_valid | output | 1 | Response word available |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | DATA_W (32) | Read word, or merged word for a write |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_we | output | 1 | 1 = write-back, 0 = block read |
| mem_req_addr | output | ADDR_W (24) | Word-aligned memory address |
| mem_req_wdata | output | DATA_W (32) | Write-back data |
| mem_ack | input | 1 | One-cycle completion of the memory request |
| mem_rdata | input | DATA_W (32) | Block data, valid with `mem_ack` on a read |

## Verification
A hit takes two clock edges from acceptance to response: one for the lookup and one to enter the response state. The bench counts those edges on every access and compares the count on hits. For a miss, the response follows the acknowledge of the fill read by one edge, and a write-back adds one more full memory round trip in front of that read. The bench therefore does not use fixed delays for misses. Its memory model counts acknowledged reads and writes and records their order, and each access waits for the response handshake before it compares those counters. The scoreboard monitor compares each response word only in the negative-edge sample where valid and ready are both high.

// File: rtl/sa2c_pkg.sv
// Shared definitions for the two-way write-back cache.
// Assumes nothing beyond the controller's five-phase sequence.
package sa2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LOOKUP    = 3'd1,
        ST_WRITEBACK = 3'd2,
        ST_FILL      = 3'd3,
        ST_RESPOND   = 3'd4
    } cstate_t;

endpackage

// File: rtl/sa2c_tag_store.sv
// Per-set line state for two ways: valid, modified, recency and tag.
// Reads are combinational at set_idx, and all updates target the same set.
// Assumes fill_en and mark_en never address the same way in one cycle.
module sa2c_tag_store #(
    parameter int TAG_W = 14,
    parameter int SET_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SET_W-1:0]      set_idx,
    output logic [1:0]            way_valid,
    output logic [1:0]            way_dirty,
    output logic [1:0]            way_use,
    output logic [1:0][TAG_W-1:0] way_tag,
    input  logic                  fill_en,
    input  logic                  fill_way,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic                  fill_dirty,
    input  logic                  mark_en,
    input  logic                  mark_way,
    input  logic                  touch_en,
    input  logic                  touch_way
);
    localparam int NSETS = 1 << SET_W;

    logic [1:0]            valid_q [NSETS];
    logic [1:0]            dirty_q [NSETS];
    logic [1:0]            use_q   [NSETS];
    logic [1:0][TAG_W-1:0] tag_q   [NSETS];

    // Keep the flag bits: cleared on reset, then set by fill, mark and touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                use_q[s]   <= '0;
            end
        end else begin
            if (fill_en) begin
                valid_q[set_idx][fill_way] <= 1'b1;
                dirty_q[set_idx][fill_way] <= fill_dirty;
            end
            if (mark_en) begin
                dirty_q[set_idx][mark_way] <= 1'b1;
            end
            if (touch_en) begin
                use_q[set_idx][touch_way]  <= 1'b1;
                use_q[set_idx][~touch_way] <= 1'b0;
            end
        end
    end

    // Store the tag of a newly installed line.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[set_idx][fill_way] <= fill_tag;
        end
    end

    assign way_valid = valid_q[set_idx];
    assign way_dirty = dirty_q[set_idx];
    assign way_use   = use_q[set_idx];
    assign way_tag   = tag_q[set_idx];

    // R9
    fill_clean_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_dirty) |=> !way_dirty[$past(fill_way)] || $past(set_idx) != set_idx);

endmodule

// File: rtl/sa2c_data_store.sv
// Data words for two ways per set. The read is combinational at set_idx
// and there is one write port into the same set. Holds no reset state.
module sa2c_data_store #(
    parameter int SET_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic [SET_W-1:0]       set_idx,
    output logic [1:0][DATA_W-1:0] way_data,
    input  logic                   wr_en,
    input  logic                   wr_way,
    input  logic [DATA_W-1:0]      wr_data
);
    localparam int NSETS = 1 << SET_W;

    logic [1:0][DATA_W-1:0] mem_q [NSETS];

    // Write one word into the selected way of the current set.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[set_idx][wr_way] <= wr_data;
        end
    end

    assign way_data = mem_q[set_idx];

endmodule

// File: rtl/sa2c_ctrl.sv
// Cache sequencer. It latches one request, compares both ways, chooses a
// victim (an invalid way first, then the way whose recency bit is clear),
// writes a modified victim back, fills, merges write bytes and responds.
// Assumes the memory port holds mem_ack for exactly one cycle per request.
module sa2c_ctrl
    import sa2c_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SET_W  = 8,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req_valid,
    output logic                   cpu_req_ready,
    input  logic                   cpu_req_we,
    input  logic [ADDR_W-1:0]      cpu_req_addr,
    input  logic [DATA_W-1:0]      cpu_req_wdata,
    input  logic [DATA_W/8-1:0]    cpu_req_be,
    output logic                   cpu_rsp_valid,
    input  logic                   cpu_rsp_ready,
    output logic [DATA_W-1:0]      cpu_rsp_rdata,
    output logic                   mem_req_valid,
    output logic                   mem_req_we,
    output logic [ADDR_W-1:0]      mem_req_addr,
    output logic [DATA_W-1:0]      mem_req_wdata,
    input  logic                   mem_ack,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic [SET_W-1:0]       set_idx,
    input  logic [1:0]             way_valid,
    input  logic [1:0]             way_dirty,
    input  logic [1:0]             way_use,
    input  logic [1:0][ADDR_W-SET_W-OFF_W-1:0] way_tag,
    input  logic [1:0][DATA_W-1:0] way_data,
    output logic                   fill_en,
    output logic                   fill_way,
    output logic [ADDR_W-SET_W-OFF_W-1:0] fill_tag,
    output logic                   fill_dirty,
    output logic                   mark_en,
    output logic                   mark_way,
    output logic                   touch_en,
    output logic                   touch_way,
    output logic                   dwr_en,
    output logic                   dwr_way,
    output logic [DATA_W-1:0]      dwr_data
);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int NBYTES = DATA_W / 8;

    cstate_t             state_q;
    logic [TAG_W-1:0]    tag_q;
    logic [SET_W-1:0]    set_q;
    logic                we_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [NBYTES-1:0]   be_q;
    logic                vic_q;
    logic [DATA_W-1:0]   rsp_q;

    logic [1:0]          hit_vec;
    logic                hit;
    logic                hit_way;
    logic                vic_way;
    logic [DATA_W-1:0]   hit_word;
    logic [DATA_W-1:0]   hit_merged;
    logic [DATA_W-1:0]   fill_merged;
    logic [DATA_W-1:0]   fill_word;

    // Compare the stored tag of each way with the latched tag.
    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == tag_q);
    end

    assign hit      = |hit_vec;
    assign hit_way  = hit_vec[1];
    assign hit_word = way_data[hit_way];

    // Victim choice: prefer an invalid way, otherwise the way not used last.
    always_comb begin
        if (!way_valid[0])      vic_way = 1'b0;
        else if (!way_valid[1]) vic_way = 1'b1;
        else                    vic_way = way_use[0];
    end

    // Byte merge of the write data over the cached word and over the fetched word.
    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        assign hit_merged[8*b +: 8]  = be_q[b] ? wdata_q[8*b +: 8] : hit_word[8*b +: 8];
        assign fill_merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : mem_rdata[8*b +: 8];
    end

    assign fill_word = we_q ? fill_merged : mem_rdata;
    assign set_idx   = set_q;

    // Drive the array strobes and the memory port from the current phase.
    always_comb begin
        fill_en       = 1'b0;
        fill_way      = vic_q;
        fill_tag      = tag_q;
        fill_dirty    = we_q;
        mark_en       = 1'b0;
        mark_way      = hit_way;
        touch_en      = 1'b0;
        touch_way     = hit_way;
        dwr_en        = 1'b0;
        dwr_way       = hit_way;
        dwr_data      = hit_merged;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = {tag_q, set_q, {OFF_W{1'b0}}};
        mem_req_wdata = way_data[vic_q];
        unique case (state_q)
            ST_LOOKUP: begin
                if (hit) begin
                    touch_en = 1'b1;
                    if (we_q) begin
                        dwr_en  = 1'b1;
                        mark_en = 1'b1;
                    end
                end
            end
            ST_WRITEBACK: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = {way_tag[vic_q], set_q, {OFF_W{1'b0}}};
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                if (mem_ack) begin
                    fill_en   = 1'b1;
                    touch_en  = 1'b1;
                    touch_way = vic_q;
                    dwr_en    = 1'b1;
                    dwr_way   = vic_q;
                    dwr_data  = fill_word;
                end
            end
            default: ;
        endcase
    end

    // Phase sequencing, request latch, victim latch and response word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tag_q   <= '0;
            set_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            be_q    <= '0;
            vic_q   <= 1'b0;
            rsp_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req_valid) begin
                        tag_q   <= cpu_req_addr[ADDR_W-1 -: TAG_W];
                        set_q   <= cpu_req_addr[OFF_W +: SET_W];
                        we_q    <= cpu_req_we;
                        wdata_q <= cpu_req_wdata;
                        be_q    <= cpu_req_be;
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        rsp_q   <= we_q ? hit_merged : hit_word;
                        state_q <= ST_RESPOND;
                    end else begin
                        vic_q   <= vic_way;
                        state_q <= (way_valid[vic_way] && way_dirty[vic_way])
                                   ? ST_WRITEBACK : ST_FILL;
                    end
                end
                ST_WRITEBACK: begin
                    if (mem_ack) state_q <= ST_FILL;
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        rsp_q   <= fill_word;
                        state_q <= ST_RESPOND;
                    end
                end
                ST_RESPOND: begin
                    if (cpu_rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_req_ready = (state_q == ST_IDLE);
    assign cpu_rsp_valid = (state_q == ST_RESPOND);
    assign cpu_rsp_rdata = rsp_q;

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));

    // R12
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> !cpu_req_ready);

    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    // R3
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && hit) |=> !mem_req_valid);

    // R8
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we && mem_ack) |=> (mem_req_valid && !mem_req_we));

endmodule

// File: rtl/sa2_wb_cache.sv
// Top level of the two-way set-associative write-back cache. It ties the
// sequencer to the line-state and data arrays. One request is served at a
// time, and addresses are byte addresses whose low OFF_W bits select a byte.
module sa2_wb_cache #(
    parameter int ADDR_W = 24,
    parameter int SET_W  = 8,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req_valid,
    output logic                cpu_req_ready,
    input  logic                cpu_req_we,
    input  logic [ADDR_W-1:0]   cpu_req_addr,
    input  logic [DATA_W-1:0]   cpu_req_wdata,
    input  logic [DATA_W/8-1:0] cpu_req_be,
    output logic                cpu_rsp_valid,
    input  logic                cpu_rsp_ready,
    output logic [DATA_W-1:0]   cpu_rsp_rdata,
    output logic                mem_req_valid,
    output logic                mem_req_we,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [DATA_W-1:0]   mem_req_wdata,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    logic [SET_W-1:0]       set_idx;
    logic [1:0]             way_valid;
    logic [1:0]             way_dirty;
    logic [1:0]             way_use;
    logic [1:0][TAG_W-1:0]  way_tag;
    logic [1:0][DATA_W-1:0] way_data;
    logic                   fill_en;
    logic                   fill_way;
    logic [TAG_W-1:0]       fill_tag;
    logic                   fill_dirty;
    logic                   mark_en;
    logic                   mark_way;
    logic                   touch_en;
    logic                   touch_way;
    logic                   dwr_en;
    logic                   dwr_way;
    logic [DATA_W-1:0]      dwr_data;

    sa2c_ctrl #(
        .ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_req_be(cpu_req_be),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
        .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .set_idx(set_idx),
        .way_valid(way_valid), .way_dirty(way_dirty), .way_use(way_use),
        .way_tag(way_tag), .way_data(way_data),
        .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_dirty(fill_dirty), .mark_en(mark_en), .mark_way(mark_way),
        .touch_en(touch_en), .touch_way(touch_way),
        .dwr_en(dwr_en), .dwr_way(dwr_way), .dwr_data(dwr_data)
    );

    sa2c_tag_store #(.TAG_W(TAG_W), .SET_W(SET_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx),
        .way_valid(way_valid), .way_dirty(way_dirty), .way_use(way_use),
        .way_tag(way_tag),
        .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_dirty(fill_dirty), .mark_en(mark_en), .mark_way(mark_way),
        .touch_en(touch_en), .touch_way(touch_way)
    );

    sa2c_data_store #(.SET_W(SET_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .set_idx(set_idx), .way_data(way_data),
        .wr_en(dwr_en), .wr_way(dwr_way), .wr_data(dwr_data)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (cpu_req_ready && !cpu_rsp_valid && !mem_req_valid));

endmodule

// File: tb/sa2_wb_cache_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the access task queues the expected response word, and
// a negative-edge monitor pops and compares it at each response handshake.
module sa2_wb_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_we = 1'b0;
    logic [23:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic [3:0]  cpu_req_be = '0;
    logic        cpu_rsp_valid;
    logic        cpu_rsp_ready = 1'b1;
    logic [31:0] cpu_rsp_rdata;
    logic        mem_req_valid;
    logic        mem_req_we;
    logic [23:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int fill_cnt = 0;
    int wb_cnt = 0;
    int mcnt = 0;
    logic [23:0] last_fill_addr = '0;
    logic [23:0] last_wb_addr = '0;
    logic [31:0] last_wb_data = '0;
    logic [3:0]  op_hist = '0;

    logic [31:0] ref_mem [logic [23:0]];
    logic [31:0] bmem    [logic [23:0]];
    logic [31:0] exp_q [$];
    string       req_q [$];

    always #2.5 clk = ~clk;

    sa2_wb_cache u_sa2_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_req_be(cpu_req_be),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
        .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(logic [23:0] a);
        return {8'hC3, a};
    endfunction

    function automatic logic [31:0] ref_rd(logic [23:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
    endfunction

    function automatic logic [31:0] mem_rd(logic [23:0] a);
        return bmem.exists(a) ? bmem[a] : init_word(a);
    endfunction

    function automatic logic [31:0] bmerge(logic [31:0] old, logic [31:0] wd, logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? wd[8*b +: 8] : old[8*b +: 8];
        return r;
    endfunction

    // Default field split: tag 23:10, set 9:2, byte 1:0.
    function automatic logic [23:0] mk(logic [13:0] t, logic [7:0] s);
        return {t, s, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: acknowledges each request after two idle cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            mcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            mcnt = 0;
        end else if (mem_req_valid) begin
            if (mcnt == 2) begin
                mem_ack = 1'b1;
                op_hist = {op_hist[2:0], mem_req_we};
                if (mem_req_we) begin
                    bmem[mem_req_addr] = mem_req_wdata;
                    last_wb_addr = mem_req_addr;
                    last_wb_data = mem_req_wdata;
                    wb_cnt++;
                end else begin
                    mem_rdata = mem_rd(mem_req_addr);
                    last_fill_addr = mem_req_addr;
                    fill_cnt++;
                end
            end else begin
                mcnt++;
            end
        end
    end

    // Monitor: compare each delivered response with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && cpu_rsp_valid && cpu_rsp_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected response", cpu_rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(cpu_rsp_rdata == e, r, cpu_rsp_rdata, e);
            end
        end
    end

    // Driver: predict the response, issue one request, await its completion.
    task automatic access(input bit we, input logic [23:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input int exp_fill, input int exp_wb,
                          input string req, output int lat);
        int f0;
        int w0;
        logic [31:0] nv;
        f0 = fill_cnt;
        w0 = wb_cnt;
        nv = we ? bmerge(ref_rd(a), wd, be) : ref_rd(a);
        if (we) ref_mem[a] = nv;
        exp_q.push_back(nv);
        req_q.push_back(req);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_addr  = a;
        cpu_req_wdata = wd;
        cpu_req_be    = be;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        // R12 busy after acceptance
        chk(cpu_req_ready == 1'b0, "R12 ready low after accept", {31'd0, cpu_req_ready}, 32'd0);
        lat = 1;
        while (!cpu_rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        while (!(cpu_rsp_valid && cpu_rsp_ready)) @(negedge clk);
        @(negedge clk);
        chk(fill_cnt - f0 == exp_fill, {req, " fill count"}, fill_cnt - f0, exp_fill);
        chk(wb_cnt - w0 == exp_wb, {req, " write-back count"}, wb_cnt - w0, exp_wb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk(cpu_req_ready && !cpu_rsp_valid && !mem_req_valid, "R1 reset outputs",
            {29'd0, cpu_req_ready, cpu_rsp_valid, mem_req_valid}, 32'h4);

        // R2 read miss fetches the aligned block and returns memory data
        access(1'b0, mk(14'h0001, 8'h05), 32'h0, 4'h0, 1, 0, "R2 read miss", lat);
        chk(last_fill_addr == mk(14'h0001, 8'h05), "R2 fill address", {8'h0, last_fill_addr}, {8'h0, mk(14'h0001, 8'h05)});
        access(1'b0, mk(14'h3FFF, 8'hFF), 32'h0, 4'h0, 1, 0, "R2 read miss top corner", lat);
        chk(last_fill_addr == mk(14'h3FFF, 8'hFF), "R2 fill address top", {8'h0, last_fill_addr}, {8'h0, mk(14'h3FFF, 8'hFF)});

        // R3 hit: no traffic, response at second edge
        access(1'b0, mk(14'h0001, 8'h05), 32'h0, 4'h0, 0, 0, "R3 read hit", lat);
        chk(lat == 2, "R3 hit latency", lat, 2);

        // R6 second tag in the same set uses the free way; first stays resident
        access(1'b0, mk(14'h0002, 8'h05), 32'h0, 4'h0, 1, 0, "R6 second block miss", lat);
        access(1'b0, mk(14'h0001, 8'h05), 32'h0, 4'h0, 0, 0, "R6 first block still hits", lat);

        // R4 write hit stays in the cache
        access(1'b1, mk(14'h0001, 8'h05), 32'hDEADBEEF, 4'hF, 0, 0, "R4 write hit", lat);
        access(1'b0, mk(14'h0001, 8'h05), 32'h0, 4'h0, 0, 0, "R4 read after write", lat);

        // R5 single byte enable merges byte 1 only
        access(1'b1, mk(14'h0001, 8'h05), 32'h0000A500, 4'b0010, 0, 0, "R5 byte merge", lat);
        access(1'b1, mk(14'h0001, 8'h05), 32'h77000011, 4'b1001, 0, 0, "R5 two byte merge", lat);

        // R7/R9 set now holds tag1 (recent, modified) and tag2 (clean): tag3 evicts tag2
        access(1'b0, mk(14'h0003, 8'h05), 32'h0, 4'h0, 1, 0, "R9 clean victim replaced", lat);
        access(1'b0, mk(14'h0001, 8'h05), 32'h0, 4'h0, 0, 0, "R7 recent line kept", lat);
        access(1'b0, mk(14'h0002, 8'h05), 32'h0, 4'h0, 1, 0, "R7 replaces least recent", lat);

        // R8 tag4 evicts modified tag1: write-back first, then fill
        held = ref_rd(mk(14'h0001, 8'h05));
        access(1'b0, mk(14'h0004, 8'h05), 32'h0, 4'h0, 1, 1, "R8 dirty eviction", lat);
        chk(last_wb_addr == mk(14'h0001, 8'h05), "R8 write-back address", {8'h0, last_wb_addr}, {8'h0, mk(14'h0001, 8'h05)});
        chk(last_wb_data == held, "R8 write-back data", last_wb_data, held);
        chk(op_hist[1:0] == 2'b10, "R8 write-back before fill", {30'd0, op_hist[1:0]}, 32'd2);
        access(1'b0, mk(14'h0001, 8'h05), 32'h0, 4'h0, 1, 0, "R8 refetch returns written data", lat);

        // R10 write miss allocates, merges and marks modified
        access(1'b1, mk(14'h0005, 8'h09), 32'h000000AB, 4'b0001, 1, 0, "R10 write miss", lat);
        access(1'b0, mk(14'h0005, 8'h09), 32'h0, 4'h0, 0, 0, "R10 read after write miss", lat);
        access(1'b0, mk(14'h0006, 8'h09), 32'h0, 4'h0, 1, 0, "R10 fill free way", lat);
        held = ref_rd(mk(14'h0005, 8'h09));
        access(1'b0, mk(14'h0007, 8'h09), 32'h0, 4'h0, 1, 1, "R10 allocated line written back", lat);
        chk(last_wb_data == held, "R10 write-back of merged word", last_wb_data, held);

        // R11 response held under back-pressure
        cpu_rsp_ready = 1'b0;
        fork
            access(1'b0, mk(14'h0006, 8'h09), 32'h0, 4'h0, 0, 0, "R11 held response", lat);
            begin
                while (!cpu_rsp_valid) @(negedge clk);
                held = cpu_rsp_rdata;
                repeat (3) @(negedge clk);
                chk(cpu_rsp_valid && cpu_rsp_rdata == held, "R11 valid and data stable",
                    cpu_rsp_rdata, held);
                chk(!cpu_req_ready, "R12 ready low while response waits",
                    {31'd0, cpu_req_ready}, 32'd0);
                cpu_rsp_ready = 1'b1;
            end
        join

        chk(exp_q.size() == 0, "R2 all responses delivered", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule